// File: doc/BRIEF.md
# Triggered Diagnostic Capture Unit

This unit fills several independent diagnostic buffers with data taken from processor memory, with no work done by processor software. Each channel watches one memory word or a run of consecutive words. On every control-cycle strobe, a channel may take one sample of that source and store it into its own region of a large buffer memory. Each channel has a decimation factor that thins the samples. Capture can also be held back until a comparison on a second, watched memory word is true. A channel can also run in the opposite direction: it replays its buffer region, one sample per strobe, into the memory words it would otherwise read.

On each strobe a single sequencer services the armed channels one at a time, lowest index first. It uses one read and one write on the processor memory port or on the buffer port, with one cycle of read latency on each. The write pointer, word count and full flag of every channel can be read at the ports. A sticky flag records any strobe that arrives before the previous service pass has finished.

Top module: `capUnit`

## Requirements
- R1: While a channel's arm bit is low, its word count reads 0, its full flag reads 0, its trigger and decimation state are cleared, and one cycle later its write pointer equals its region base. After reset all counts, full flags and the overrun flag read 0.
- R2: On a serviced strobe, a forward channel copies the source words at `src`, `src+1`, … `src+L-1` (where L is the length field plus 1) into consecutive buffer addresses starting at its write pointer. The word count and the pointer each advance by one per word.
- R3: With decimation field D, where 0 is treated as 1, an enabled channel samples on the first eligible strobe and then on every D-th strobe after it.
- R4: With the trigger enabled, the watched word W is compared unsigned against the reference R. Operation code 0 tests W==R, code 1 tests W<R, code 2 tests W>R, and code 3 never fires. No sample is taken until the comparison is true on a strobe, and the sample is taken on that same strobe.
- R5: Once the trigger has fired, later strobes capture without looking at the watched word again, until the channel is disarmed.
- R6: In linear mode, after the last word of the region (base+size-1) is written, the full flag is set and the pointer rests at base+size. No further transfer happens for that channel, even in the middle of a vector.
- R7: In circular mode, the pointer wraps from base+size-1 back to base, and the full flag never sets.
- R8: A channel in reverse mode reads its buffer at the write pointer and writes that value to memory word `src+i` for i = 0…L-1. The pointer, the count and the linear/circular rules work as in forward mode.
- R9: Within one strobe the armed, non-full channels are serviced in ascending index order, so the bus writes of channel i come before those of channel j>i.
- R10: A strobe that arrives while a service pass is still running is dropped and sets the overrun flag. The flag stays set until reset.
- R11: The unit never asserts the memory write and the buffer write in the same cycle, and never asserts both reads in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStrobe | input | 1 | One-cycle control-cycle strobe |
| cfgArm | input | NCH | Per-channel arm; low clears the channel |
| cfgCircular | input | NCH | 1 = circular region, 0 = linear |
| cfgReverse | input | NCH | 1 = replay buffer into memory |
| cfgTrigEn | input | NCH | Enable trigger gating |
| cfgTrigOp | input | NCH*2 | Compare code per channel (0 eq, 1 lt, 2 gt, 3 never) |
| cfgSrcAddr | input | NCH*AW | First memory word of the vector |
| cfgVecLenM1 | input | NCH*LW | Vector length minus one |
| cfgDecim | input | NCH*DECW | Decimation factor |
| cfgWatchAddr | input | NCH*AW | Watched memory word for the trigger |
| cfgTrigRef | input | NCH*DW | Trigger reference value |
| cfgBufBase | input | NCH*BAW | Region base in buffer memory |
| cfgBufSize | input | NCH*BAW | Region size in words (at least 1) |
| memRdEn | output | 1 | Processor memory read request |
| memRdAddr | output | AW | Processor memory read address |
| memRdData | input | DW | Read data, valid the cycle after the request |
| memWrEn | output | 1 | Processor memory write |
| memWrAddr | output | AW | Processor memory write address |
| memWrData | output | DW | Processor memory write data |
| bufRdEn | output | 1 | Buffer read request |
| bufRdAddr | output | BAW | Buffer read address |
| bufRdData | input | DW | Buffer read data, valid the cycle after the request |
| bufWrEn | output | 1 | Buffer write |
| bufWrAddr | output | BAW | Buffer write address |
| bufWrData | output | DW | Buffer write data |
| stWrPtr | output | NCH*BAW | Current pointer of each channel |
| stCount | output | NCH*CNTW | Words moved by each channel since arming |
| stFull | output | NCH | Linear region exhausted |
| stOverrun | output | 1 | Sticky overrun flag |

## Verification
The assertions assume the following about the inputs:
- A channel's configuration stays constant while it is armed.
- Every region size is at least 1.
- Read data arrives exactly one cycle after a read request.

The stimulus respects these assumptions in three ways:
- It changes a channel's settings only while that channel's arm bit is low and the sequencer has finished its pass.
- It gives every region a non-zero size inside the modelled buffer.
- Its memory models always answer after one cycle.

Strobes are spaced well beyond the longest service pass, except in the one sequence that provokes an overrun on purpose.

// File: rtl/capPkg.sv
package capPkg;

  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_LT  = 2'd1,
    CMP_GT  = 2'd2,
    CMP_OFF = 2'd3
  } cmpOp_e;

  typedef enum logic [2:0] {
    SV_IDLE,
    SV_SCAN,
    SV_GATE,
    SV_TRIGRD,
    SV_TRIGCMP,
    SV_XRD,
    SV_XWR
  } svcState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic setTrig;
    logic decTake;
    logic decSkip;
    logic advance;
    logic trigRd;
    logic xferRd;
    logic xferWr;
  } chanStrobe_t;

endpackage

// File: rtl/capDatapath.sv
module capDatapath
  import capPkg::*;
#(
  parameter int NCH  = 6,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int BAW  = 12,
  parameter int LW   = 4,
  parameter int DECW = 8,
  parameter int CNTW = 16,
  parameter int SW   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    cfgArm,
  input  logic [NCH-1:0]    cfgCircular,
  input  logic [NCH-1:0]    cfgReverse,
  input  logic [NCH-1:0]    cfgTrigEn,
  input  logic [NCH*2-1:0]  cfgTrigOp,
  input  logic [NCH*AW-1:0] cfgSrcAddr,
  input  logic [NCH*LW-1:0] cfgVecLenM1,
  input  logic [NCH*DECW-1:0] cfgDecim,
  input  logic [NCH*AW-1:0] cfgWatchAddr,
  input  logic [NCH*DW-1:0] cfgTrigRef,
  input  logic [NCH*BAW-1:0] cfgBufBase,
  input  logic [NCH*BAW-1:0] cfgBufSize,
  input  logic [SW-1:0]     sel,
  input  logic [LW-1:0]     wordIdx,
  input  chanStrobe_t       stb,
  output logic [NCH-1:0]    fullMask,
  output logic              selTrigWait,
  output logic              selDecZero,
  output logic              selStop,
  output logic              trigPass,
  output logic              memRdEn,
  output logic [AW-1:0]     memRdAddr,
  input  logic [DW-1:0]     memRdData,
  output logic              memWrEn,
  output logic [AW-1:0]     memWrAddr,
  output logic [DW-1:0]     memWrData,
  output logic              bufRdEn,
  output logic [BAW-1:0]    bufRdAddr,
  input  logic [DW-1:0]     bufRdData,
  output logic              bufWrEn,
  output logic [BAW-1:0]    bufWrAddr,
  output logic [DW-1:0]     bufWrData,
  output logic [NCH*BAW-1:0] stWrPtr,
  output logic [NCH*CNTW-1:0] stCount
);

  logic [BAW-1:0]  ptrA  [NCH];
  logic [CNTW-1:0] cntA  [NCH];
  logic [DECW-1:0] decA  [NCH];
  logic [NCH-1:0]  trigQ;
  logic [NCH-1:0]  fullQ;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : gChan
      logic [BAW-1:0]  base;
      logic [BAW-1:0]  lastAddr;
      logic [DECW-1:0] decim;
      logic            hit;

      assign base     = cfgBufBase[g*BAW +: BAW];
      assign lastAddr = base + cfgBufSize[g*BAW +: BAW] - BAW'(1);
      assign decim    = cfgDecim[g*DECW +: DECW];
      assign hit      = (sel == SW'(g));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ptrA[g]  <= '0;
          cntA[g]  <= '0;
          decA[g]  <= '0;
          trigQ[g] <= 1'b0;
          fullQ[g] <= 1'b0;
        end else if (!cfgArm[g]) begin
          ptrA[g]  <= base;
          cntA[g]  <= '0;
          decA[g]  <= '0;
          trigQ[g] <= 1'b0;
          fullQ[g] <= 1'b0;
        end else if (hit) begin
          if (stb.setTrig) trigQ[g] <= 1'b1;
          if (stb.decTake)
            decA[g] <= (decim == '0) ? '0 : decim - DECW'(1);
          else if (stb.decSkip)
            decA[g] <= decA[g] - DECW'(1);
          if (stb.advance) begin
            cntA[g] <= cntA[g] + CNTW'(1);
            if (ptrA[g] == lastAddr && cfgCircular[g]) begin
              ptrA[g] <= base;
            end else begin
              ptrA[g] <= ptrA[g] + BAW'(1);
              if (ptrA[g] == lastAddr) fullQ[g] <= 1'b1;
            end
          end
        end
      end

      assign stWrPtr[g*BAW +: BAW]  = ptrA[g];
      assign stCount[g*CNTW +: CNTW] = cntA[g];
    end
  endgenerate

  assign fullMask = fullQ;

  // selected-channel view
  logic [BAW-1:0]  selPtr;
  logic [BAW-1:0]  selLast;
  logic [AW-1:0]   selSrc;
  logic [AW-1:0]   selWatch;
  logic [DW-1:0]   selRef;
  logic [1:0]      selOp;
  logic [LW-1:0]   selLenM1;
  logic            selRev;
  logic            selCirc;
  logic            selTrigEn;
  logic            selTrigd;
  logic [DECW-1:0] selDec;

  always_comb begin
    selPtr    = '0;
    selLast   = '0;
    selSrc    = '0;
    selWatch  = '0;
    selRef    = '0;
    selOp     = '0;
    selLenM1  = '0;
    selRev    = 1'b0;
    selCirc   = 1'b0;
    selTrigEn = 1'b0;
    selTrigd  = 1'b0;
    selDec    = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel == SW'(i)) begin
        selPtr    = ptrA[i];
        selLast   = cfgBufBase[i*BAW +: BAW] + cfgBufSize[i*BAW +: BAW] - BAW'(1);
        selSrc    = cfgSrcAddr[i*AW +: AW];
        selWatch  = cfgWatchAddr[i*AW +: AW];
        selRef    = cfgTrigRef[i*DW +: DW];
        selOp     = cfgTrigOp[i*2 +: 2];
        selLenM1  = cfgVecLenM1[i*LW +: LW];
        selRev    = cfgReverse[i];
        selCirc   = cfgCircular[i];
        selTrigEn = cfgTrigEn[i];
        selTrigd  = trigQ[i];
        selDec    = decA[i];
      end
    end
  end

  assign selTrigWait = selTrigEn & ~selTrigd;
  assign selDecZero  = (selDec == '0);
  assign selStop     = (wordIdx == selLenM1) | (~selCirc & (selPtr == selLast));

  always_comb begin
    case (cmpOp_e'(selOp))
      CMP_EQ:  trigPass = (memRdData == selRef);
      CMP_LT:  trigPass = (memRdData <  selRef);
      CMP_GT:  trigPass = (memRdData >  selRef);
      default: trigPass = 1'b0;
    endcase
  end

  logic [AW-1:0] wordAddr;
  assign wordAddr = selSrc + AW'(wordIdx);

  assign memRdEn   = stb.trigRd | (stb.xferRd & ~selRev);
  assign memRdAddr = stb.trigRd ? selWatch : wordAddr;
  assign bufRdEn   = stb.xferRd & selRev;
  assign bufRdAddr = selPtr;
  assign bufWrEn   = stb.xferWr & ~selRev;
  assign bufWrAddr = selPtr;
  assign bufWrData = memRdData;
  assign memWrEn   = stb.xferWr & selRev;
  assign memWrAddr = wordAddr;
  assign memWrData = bufRdData;

endmodule

// File: rtl/capSequencer.sv
module capSequencer
  import capPkg::*;
#(
  parameter int NCH = 6,
  parameter int LW  = 4,
  parameter int SW  = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cycleStrobe,
  input  logic [NCH-1:0] armMask,
  input  logic [NCH-1:0] fullMask,
  input  logic           selTrigWait,
  input  logic           selDecZero,
  input  logic           selStop,
  input  logic           trigPass,
  output logic [SW-1:0]  sel,
  output logic [LW-1:0]  wordIdx,
  output chanStrobe_t    stb,
  output logic           svcBusy,
  output logic           overrun
);

  svcState_e      state;
  logic [NCH-1:0] pending;
  logic [SW-1:0]  pickIdx;

  always_comb begin
    pickIdx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending[i]) pickIdx = SW'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SV_IDLE;
      pending <= '0;
      sel     <= '0;
      wordIdx <= '0;
      overrun <= 1'b0;
    end else begin
      if (cycleStrobe && state != SV_IDLE) overrun <= 1'b1;
      case (state)
        SV_IDLE: begin
          if (cycleStrobe) begin
            pending <= armMask & ~fullMask;
            state   <= SV_SCAN;
          end
        end
        SV_SCAN: begin
          if (pending == '0) begin
            state <= SV_IDLE;
          end else begin
            sel              <= pickIdx;
            pending[pickIdx] <= 1'b0;
            state            <= SV_GATE;
          end
        end
        SV_GATE: begin
          if (selTrigWait) begin
            state <= SV_TRIGRD;
          end else if (selDecZero) begin
            wordIdx <= '0;
            state   <= SV_XRD;
          end else begin
            state <= SV_SCAN;
          end
        end
        SV_TRIGRD: state <= SV_TRIGCMP;
        SV_TRIGCMP: begin
          if (trigPass && selDecZero) begin
            wordIdx <= '0;
            state   <= SV_XRD;
          end else begin
            state <= SV_SCAN;
          end
        end
        SV_XRD: state <= SV_XWR;
        SV_XWR: begin
          if (selStop) begin
            state <= SV_SCAN;
          end else begin
            wordIdx <= wordIdx + LW'(1);
            state   <= SV_XRD;
          end
        end
        default: state <= SV_IDLE;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    case (state)
      SV_GATE: begin
        if (!selTrigWait) begin
          stb.decTake = selDecZero;
          stb.decSkip = ~selDecZero;
        end
      end
      SV_TRIGRD: stb.trigRd = 1'b1;
      SV_TRIGCMP: begin
        if (trigPass) begin
          stb.setTrig = 1'b1;
          stb.decTake = selDecZero;
          stb.decSkip = ~selDecZero;
        end
      end
      SV_XRD: stb.xferRd = 1'b1;
      SV_XWR: begin
        stb.xferWr  = 1'b1;
        stb.advance = 1'b1;
      end
      default: ;
    endcase
  end

  assign svcBusy = (state != SV_IDLE);

endmodule

// File: rtl/capUnit.sv
module capUnit
  import capPkg::*;
#(
  parameter int NCH  = 6,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int BAW  = 12,
  parameter int LW   = 4,
  parameter int DECW = 8,
  parameter int CNTW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cycleStrobe,
  input  logic [NCH-1:0]      cfgArm,
  input  logic [NCH-1:0]      cfgCircular,
  input  logic [NCH-1:0]      cfgReverse,
  input  logic [NCH-1:0]      cfgTrigEn,
  input  logic [NCH*2-1:0]    cfgTrigOp,
  input  logic [NCH*AW-1:0]   cfgSrcAddr,
  input  logic [NCH*LW-1:0]   cfgVecLenM1,
  input  logic [NCH*DECW-1:0] cfgDecim,
  input  logic [NCH*AW-1:0]   cfgWatchAddr,
  input  logic [NCH*DW-1:0]   cfgTrigRef,
  input  logic [NCH*BAW-1:0]  cfgBufBase,
  input  logic [NCH*BAW-1:0]  cfgBufSize,
  output logic                memRdEn,
  output logic [AW-1:0]       memRdAddr,
  input  logic [DW-1:0]       memRdData,
  output logic                memWrEn,
  output logic [AW-1:0]       memWrAddr,
  output logic [DW-1:0]       memWrData,
  output logic                bufRdEn,
  output logic [BAW-1:0]      bufRdAddr,
  input  logic [DW-1:0]       bufRdData,
  output logic                bufWrEn,
  output logic [BAW-1:0]      bufWrAddr,
  output logic [DW-1:0]       bufWrData,
  output logic [NCH*BAW-1:0]  stWrPtr,
  output logic [NCH*CNTW-1:0] stCount,
  output logic [NCH-1:0]      stFull,
  output logic                stOverrun
);

  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [SW-1:0] sel;
  logic [LW-1:0] wordIdx;
  chanStrobe_t   stb;
  logic          selTrigWait;
  logic          selDecZero;
  logic          selStop;
  logic          trigPass;
  logic          svcBusy;

  capSequencer #(.NCH(NCH), .LW(LW), .SW(SW)) uSeq (
    .clk         (clk),
    .rstN        (rstN),
    .cycleStrobe (cycleStrobe),
    .armMask     (cfgArm),
    .fullMask    (stFull),
    .selTrigWait (selTrigWait),
    .selDecZero  (selDecZero),
    .selStop     (selStop),
    .trigPass    (trigPass),
    .sel         (sel),
    .wordIdx     (wordIdx),
    .stb         (stb),
    .svcBusy     (svcBusy),
    .overrun     (stOverrun)
  );

  capDatapath #(
    .NCH(NCH), .AW(AW), .DW(DW), .BAW(BAW), .LW(LW),
    .DECW(DECW), .CNTW(CNTW), .SW(SW)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgArm       (cfgArm),
    .cfgCircular  (cfgCircular),
    .cfgReverse   (cfgReverse),
    .cfgTrigEn    (cfgTrigEn),
    .cfgTrigOp    (cfgTrigOp),
    .cfgSrcAddr   (cfgSrcAddr),
    .cfgVecLenM1  (cfgVecLenM1),
    .cfgDecim     (cfgDecim),
    .cfgWatchAddr (cfgWatchAddr),
    .cfgTrigRef   (cfgTrigRef),
    .cfgBufBase   (cfgBufBase),
    .cfgBufSize   (cfgBufSize),
    .sel          (sel),
    .wordIdx      (wordIdx),
    .stb          (stb),
    .fullMask     (stFull),
    .selTrigWait  (selTrigWait),
    .selDecZero   (selDecZero),
    .selStop      (selStop),
    .trigPass     (trigPass),
    .memRdEn      (memRdEn),
    .memRdAddr    (memRdAddr),
    .memRdData    (memRdData),
    .memWrEn      (memWrEn),
    .memWrAddr    (memWrAddr),
    .memWrData    (memWrData),
    .bufRdEn      (bufRdEn),
    .bufRdAddr    (bufRdAddr),
    .bufRdData    (bufRdData),
    .bufWrEn      (bufWrEn),
    .bufWrAddr    (bufWrAddr),
    .bufWrData    (bufWrData),
    .stWrPtr      (stWrPtr),
    .stCount      (stCount)
  );

endmodule

// File: rtl/capChecker.sv
module capChecker #(
  parameter int NCH  = 6,
  parameter int BAW  = 12,
  parameter int CNTW = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                cycleStrobe,
  input logic                svcBusy,
  input logic [NCH-1:0]      cfgArm,
  input logic [NCH-1:0]      cfgCircular,
  input logic                memRdEn,
  input logic                memWrEn,
  input logic                bufRdEn,
  input logic                bufWrEn,
  input logic [NCH*BAW-1:0]  stWrPtr,
  input logic [NCH*CNTW-1:0] stCount,
  input logic [NCH-1:0]      stFull,
  input logic                stOverrun
);

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stOverrun |=> stOverrun);

  // R10
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStrobe && svcBusy) |=> stOverrun);

  // R11
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && bufWrEn));

  // R11
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && bufRdEn));

  // R2
  fwd_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> $past(memRdEn));

  // R8
  rev_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(bufRdEn));

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : gChk
      // R1
      disarm_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        !cfgArm[g] |=> (stCount[g*CNTW +: CNTW] == '0) && !stFull[g]);

      // R6
      full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (stFull[g] && cfgArm[g]) |=> $stable(stWrPtr[g*BAW +: BAW]));

      // R7
      circ_nofull_chk: assert property (@(posedge clk) disable iff (!rstN)
        (cfgArm[g] && cfgCircular[g] && !stFull[g]) |=> !stFull[g]);
    end
  endgenerate

endmodule

bind capUnit capChecker #(.NCH(NCH), .BAW(BAW), .CNTW(CNTW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .cycleStrobe (cycleStrobe),
  .svcBusy     (svcBusy),
  .cfgArm      (cfgArm),
  .cfgCircular (cfgCircular),
  .memRdEn     (memRdEn),
  .memWrEn     (memWrEn),
  .bufRdEn     (bufRdEn),
  .bufWrEn     (bufWrEn),
  .stWrPtr     (stWrPtr),
  .stCount     (stCount),
  .stFull      (stFull),
  .stOverrun   (stOverrun)
);

// File: tb/sim_capUnit.sv
`timescale 1ns/1ps
module sim_capUnit;

  localparam int NCH = 6, AW = 16, DW = 32, BAW = 12, LW = 4, DECW = 8, CNTW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStrobe = 1'b0;
  logic [NCH-1:0] cfgArm = '0, cfgCircular = '0, cfgReverse = '0, cfgTrigEn = '0;
  logic [NCH*2-1:0] cfgTrigOp = '0;
  logic [NCH*AW-1:0] cfgSrcAddr = '0, cfgWatchAddr = '0;
  logic [NCH*LW-1:0] cfgVecLenM1 = '0;
  logic [NCH*DECW-1:0] cfgDecim = '0;
  logic [NCH*DW-1:0] cfgTrigRef = '0;
  logic [NCH*BAW-1:0] cfgBufBase = '0, cfgBufSize = '0;
  logic memRdEn, memWrEn, bufRdEn, bufWrEn;
  logic [AW-1:0] memRdAddr, memWrAddr;
  logic [BAW-1:0] bufRdAddr, bufWrAddr;
  logic [DW-1:0] memRdData = '0, bufRdData = '0, memWrData, bufWrData;
  logic [NCH*BAW-1:0] stWrPtr;
  logic [NCH*CNTW-1:0] stCount;
  logic [NCH-1:0] stFull;
  logic stOverrun;

  always #4 clk = ~clk;

  capUnit u0 (.*);

  logic [DW-1:0] procMem [256];
  logic [DW-1:0] bufMem [1024];

  always @(posedge clk) begin
    if (memRdEn) memRdData <= procMem[memRdAddr[7:0]];
    if (memWrEn) procMem[memWrAddr[7:0]] <= memWrData;
    if (bufRdEn) bufRdData <= bufMem[bufRdAddr[9:0]];
    if (bufWrEn) bufMem[bufWrAddr[9:0]] <= bufWrData;
  end

  int checks = 0;
  int errors = 0;
  int collide = 0;
  string phaseTag = "R1";

  typedef struct {
    bit toBuf;
    int addr;
    logic [31:0] data;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  task automatic expectWr(bit toBuf, int addr, logic [31:0] data, string tag);
    expItem_t e;
    e.toBuf = toBuf; e.addr = addr; e.data = data; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic gotWrite(bit toBuf, int addr, logic [31:0] data);
    expItem_t e;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected write buf=%0d addr=%0d data=%h, expected none",
               phaseTag, toBuf, addr, data);
    end else begin
      e = expQ.pop_front();
      if (e.toBuf != toBuf || e.addr != addr || e.data !== data) begin
        errors++;
        $display("FAIL %s write buf=%0d addr=%0d data=%h, expected buf=%0d addr=%0d data=%h",
                 e.tag, toBuf, addr, data, e.toBuf, e.addr, e.data);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (bufWrEn && memWrEn) collide++;
      if (memRdEn && bufRdEn) collide++;
      if (bufWrEn) gotWrite(1'b1, int'(bufWrAddr), bufWrData);
      if (memWrEn) gotWrite(1'b0, int'(memWrAddr), memWrData);
    end
  end

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ptrOf(int ch);
    return int'(stWrPtr[ch*BAW +: BAW]);
  endfunction
  function automatic int cntOf(int ch);
    return int'(stCount[ch*CNTW +: CNTW]);
  endfunction

  task automatic setChan(int ch, bit circ, bit rev, bit tEn, int op, int src, int lenM1,
                         int dec, int watch, int refv, int base, int size);
    cfgCircular[ch] = circ;
    cfgReverse[ch]  = rev;
    cfgTrigEn[ch]   = tEn;
    cfgTrigOp[ch*2 +: 2]        = op[1:0];
    cfgSrcAddr[ch*AW +: AW]     = src[AW-1:0];
    cfgVecLenM1[ch*LW +: LW]    = lenM1[LW-1:0];
    cfgDecim[ch*DECW +: DECW]   = dec[DECW-1:0];
    cfgWatchAddr[ch*AW +: AW]   = watch[AW-1:0];
    cfgTrigRef[ch*DW +: DW]     = refv;
    cfgBufBase[ch*BAW +: BAW]   = base[BAW-1:0];
    cfgBufSize[ch*BAW +: BAW]   = size[BAW-1:0];
  endtask

  task automatic pulse();
    @(negedge clk) cycleStrobe = 1'b1;
    @(negedge clk) cycleStrobe = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic disarmAll();
    @(negedge clk) cfgArm = '0;
    repeat (2) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int i = 0; i < 256; i++) procMem[i] = '0;
    for (int i = 0; i < 1024; i++) bufMem[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    phaseTag = "R1";
    for (int c = 0; c < NCH; c++) checkEq("R1 count after reset", cntOf(c), 0);
    checkEq("R1 full after reset", int'(stFull), 0);
    checkEq("R10 overrun after reset", int'(stOverrun), 0);

    // R2 / R6 forward linear vector
    phaseTag = "R2";
    setChan(0, 0, 0, 0, 0, 'h10, 2, 1, 0, 0, 100, 8);
    @(negedge clk) cfgArm[0] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      procMem['h10 + i] = 32'hA0 + i;
      expectWr(1, 100 + i, 32'hA0 + i, "R2");
    end
    pulse();
    checkEq("R2 pointer", ptrOf(0), 103);
    checkEq("R2 count", cntOf(0), 3);
    for (int i = 0; i < 3; i++) begin
      procMem['h10 + i] = 32'hB0 + i;
      expectWr(1, 103 + i, 32'hB0 + i, "R2");
    end
    pulse();
    phaseTag = "R6";
    for (int i = 0; i < 3; i++) procMem['h10 + i] = 32'hC0 + i;
    expectWr(1, 106, 32'hC0, "R6");
    expectWr(1, 107, 32'hC1, "R6");
    pulse();
    checkEq("R6 full flag", int'(stFull[0]), 1);
    checkEq("R6 pointer at end", ptrOf(0), 108);
    pulse();
    checkEq("R6 count after extra strobe", cntOf(0), 8);
    phaseTag = "R1";
    disarmAll();
    checkEq("R1 disarm pointer", ptrOf(0), 100);
    checkEq("R1 disarm count", cntOf(0), 0);
    checkEq("R1 disarm full", int'(stFull[0]), 0);

    // R3 / R7 decimation and circular wrap
    phaseTag = "R3";
    setChan(1, 1, 0, 0, 0, 'h20, 0, 2, 0, 0, 200, 3);
    @(negedge clk) cfgArm[1] = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      procMem['h20] = k * 16 + 1;
      if (k % 2 == 1) begin
        case (k)
          1: expectWr(1, 200, k * 16 + 1, "R3");
          3: expectWr(1, 201, k * 16 + 1, "R3");
          5: expectWr(1, 202, k * 16 + 1, "R3");
          default: expectWr(1, 200, k * 16 + 1, "R7");
        endcase
      end
      pulse();
    end
    checkEq("R7 wrapped pointer", ptrOf(1), 201);
    checkEq("R3 decimated count", cntOf(1), 4);
    checkEq("R7 no full", int'(stFull[1]), 0);
    disarmAll();

    // R4 / R5 greater-than trigger and latch
    phaseTag = "R4";
    setChan(2, 0, 0, 1, 2, 'h30, 0, 1, 'h31, 5, 300, 16);
    @(negedge clk) cfgArm[2] = 1'b1;
    procMem['h30] = 32'h111; procMem['h31] = 3;
    pulse();
    checkEq("R4 gt not met", cntOf(2), 0);
    procMem['h30] = 32'h222; procMem['h31] = 9;
    expectWr(1, 300, 32'h222, "R4");
    pulse();
    phaseTag = "R5";
    procMem['h30] = 32'h333; procMem['h31] = 1;
    expectWr(1, 301, 32'h333, "R5");
    pulse();
    checkEq("R5 latched count", cntOf(2), 2);
    disarmAll();

    // R4 eq / lt / never, R9 priority order
    phaseTag = "R4";
    setChan(3, 0, 0, 1, 0, 'h40, 0, 1, 'h41, 7, 350, 4);
    setChan(4, 0, 0, 1, 1, 'h50, 0, 1, 'h51, 5, 400, 4);
    setChan(5, 0, 0, 0, 0, 'h58, 0, 1, 0, 0, 500, 4);
    setChan(1, 0, 0, 1, 3, 'h20, 0, 1, 'h51, 4, 450, 4);
    procMem['h40] = 32'h40404040; procMem['h41] = 6;
    procMem['h50] = 32'h50505050; procMem['h51] = 4;
    procMem['h58] = 32'h58585858;
    @(negedge clk) cfgArm = 6'b111010;
    expectWr(1, 400, 32'h50505050, "R4");
    expectWr(1, 500, 32'h58585858, "R4");
    pulse();
    checkEq("R4 eq not met", cntOf(3), 0);
    checkEq("R4 code 3 never fires", cntOf(1), 0);
    phaseTag = "R9";
    procMem['h41] = 7;
    expectWr(1, 350, 32'h40404040, "R9");
    expectWr(1, 401, 32'h50505050, "R9");
    expectWr(1, 501, 32'h58585858, "R9");
    pulse();
    checkEq("R4 eq met count", cntOf(3), 1);
    checkEq("R4 code 3 still idle", cntOf(1), 0);
    disarmAll();

    // R8 reverse replay
    phaseTag = "R8";
    setChan(0, 0, 1, 0, 0, 'h60, 1, 1, 0, 0, 600, 4);
    for (int i = 0; i < 4; i++) bufMem[600 + i] = 32'hD0 + i;
    @(negedge clk) cfgArm[0] = 1'b1;
    expectWr(0, 'h60, 32'hD0, "R8");
    expectWr(0, 'h61, 32'hD1, "R8");
    pulse();
    expectWr(0, 'h60, 32'hD2, "R8");
    expectWr(0, 'h61, 32'hD3, "R8");
    pulse();
    checkEq("R8 memory word", int'(procMem['h61]), 32'hD3);
    checkEq("R8 reverse full", int'(stFull[0]), 1);
    disarmAll();

    // R10 overrun
    phaseTag = "R10";
    checkEq("R10 overrun clear before", int'(stOverrun), 0);
    setChan(0, 1, 0, 0, 0, 'h70, 15, 1, 0, 0, 700, 64);
    for (int i = 0; i < 16; i++) begin
      procMem['h70 + i] = 32'hE000 + i;
      expectWr(1, 700 + i, 32'hE000 + i, "R10");
    end
    @(negedge clk) cfgArm[0] = 1'b1;
    @(negedge clk) cycleStrobe = 1'b1;
    @(negedge clk) cycleStrobe = 1'b0;
    repeat (4) @(negedge clk);
    cycleStrobe = 1'b1;
    @(negedge clk) cycleStrobe = 1'b0;
    repeat (100) @(negedge clk);
    checkEq("R10 overrun set", int'(stOverrun), 1);
    checkEq("R10 dropped strobe count", cntOf(0), 16);
    checkEq("R10 pointer", ptrOf(0), 716);

    // R11 and scoreboard drain
    checkEq("R11 port collisions", collide, 0);
    checkEq("R2 leftover expected writes", expQ.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog %s timeout actual=running expected=done", phaseTag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule